// File: doc/BRIEF.md
# Byte Shift and Rotate Unit with Flag Updates

This execution unit takes one byte operand and applies one of seven shift or rotate operations to it: rotate left, rotate right, rotate left through carry, rotate right through carry, logical shift left, logical shift right and arithmetic shift right. The shift count comes from one of three places: the constant one, an immediate byte, or a count-register byte. Each operation class reduces that raw count in its own way before it is used.

The unit produces the result byte, a write-back enable, and an update enable plus a new value for each of the carry, overflow, sign, zero and parity flags. It has one clocked output stage. A result appears on the outputs one clock edge after its inputs are presented, and a new operation can be accepted every cycle. When the effective count is zero, nothing is written and no flag changes. Decoding, register access and memory sequencing belong to the surrounding pipeline.

Top module: `shr_byte_unit`

## Requirements
- R1: All outputs are registered. The outputs present the operation whose inputs were sampled at the previous rising clock edge. While the synchronous active-high reset is held, every output is 0.
- R2: The `cnt_src` input selects the raw count. The value 0 selects the constant 1, the value 1 selects `cnt_imm`, and the values 2 and 3 select `cnt_reg`.
- R3: The `op_sel` value 0 selects rotate left and the value 1 selects rotate right. Both use the raw count modulo 8. After a rotate left, CF equals result bit 0. After a rotate right, CF equals result bit 7.
- R4: The `op_sel` value 2 selects rotate left through carry and the value 3 selects rotate right through carry. The effective count is (raw mod 32) mod 9. The rotation acts on the 9-bit value {carry_in, operand}. After a left rotation, CF takes operand bit (8 − count). After a right rotation, CF takes operand bit (count − 1).
- R5: For every rotate, OF is updated only when the effective count is 1. Its value is then operand bit 7 XOR result bit 7.
- R6: A rotate with a nonzero count leaves SF, ZF and PF untouched: their update enables stay 0.
- R7: The `op_sel` value 4 selects logical shift left, the value 5 selects logical shift right and the value 7 selects arithmetic shift right. Each uses the raw count modulo 32. CF receives the last bit shifted out, which is 0 for a logical shift by more than 8. An arithmetic shift fills the vacated bits with the operand sign bit, so a count of 8 or more gives 0xFF or 0x00 and sets CF to the sign bit.
- R8: A shift with a nonzero count updates SF (result bit 7), ZF (result equals 0) and PF (1 when the result holds an even number of ones). At a count of 1, OF is also updated: shift left gives result bit 7 XOR CF, logical shift right gives operand bit 7, and arithmetic shift right gives 0.
- R9: When the effective count is 0, or when `op_sel` is 6, `wr_en` and every flag update enable are 0, and `result` equals the operand.
- R10: Each flag value output reads 0 whenever its update enable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation select |
| cnt_src | input | 2 | Count source select |
| cnt_imm | input | 8 | Immediate count byte |
| cnt_reg | input | 8 | Count-register byte |
| operand | input | 8 | Operand byte |
| carry_in | input | 1 | Incoming carry flag |
| result | output | 8 | Result byte |
| wr_en | output | 1 | Result write-back enable |
| cf_we | output | 1 | Carry flag update enable |
| cf_out | output | 1 | New carry flag value |
| of_we | output | 1 | Overflow flag update enable |
| of_out | output | 1 | New overflow flag value |
| sf_we | output | 1 | Sign flag update enable |
| sf_out | output | 1 | New sign flag value |
| zf_we | output | 1 | Zero flag update enable |
| zf_out | output | 1 | New zero flag value |
| pf_we | output | 1 | Parity flag update enable |
| pf_out | output | 1 | New parity flag value |

## Verification
The assertions check several rules on every cycle:
- No flag enable is raised without a write-back.
- Idle cycles pass the operand through unchanged.
- Disabled flags read 0.
- Parity agrees with the result byte.
- Rotates never touch SF, ZF or PF.
- Rotate left ties CF to result bit 0.
- An arithmetic shift by one clears OF.

Other behaviour only the bench's sweep can show. This covers the exact result bits, the count reduction for each class (modulo 8, modulo 9 of five bits, five bits), the carry-through rotation, the last-bit-out carry beyond a count of 8, and the choice among the three count sources. The sweep covers every operation, operand, count and carry-in value.

// File: rtl/shr_pkg.sv
package shr_pkg;

    typedef enum logic [2:0] {
        OP_ROL  = 3'd0,
        OP_ROR  = 3'd1,
        OP_RCL  = 3'd2,
        OP_RCR  = 3'd3,
        OP_SHL  = 3'd4,
        OP_SHR  = 3'd5,
        OP_NONE = 3'd6,
        OP_SAR  = 3'd7
    } shr_op_e;

    typedef enum logic [1:0] {
        SRC_ONE     = 2'd0,
        SRC_IMM     = 2'd1,
        SRC_REG     = 2'd2,
        SRC_REG_ALT = 2'd3
    } shr_src_e;

    // one flag: update enable plus new value
    typedef struct packed {
        logic we;
        logic val;
    } flag_t;

    typedef struct packed {
        flag_t cf;
        flag_t ovf;
        flag_t sgn;
        flag_t zro;
        flag_t par;
    } flag_set_t;

    localparam flag_t FLAG_KEEP = '{we: 1'b0, val: 1'b0};

    function automatic logic is_rotate(shr_op_e op);
        return (op == OP_ROL) || (op == OP_ROR) || (op == OP_RCL) || (op == OP_RCR);
    endfunction

    function automatic logic is_shift(shr_op_e op);
        return (op == OP_SHL) || (op == OP_SHR) || (op == OP_SAR);
    endfunction

    function automatic flag_t mk_flag(logic en, logic v);
        return '{we: en, val: en & v};
    endfunction

endpackage

// File: rtl/shr_count_sel.sv
module shr_count_sel
    import shr_pkg::*;
#(
    parameter int W     = 8,
    parameter int CIN_W = 8,
    parameter int SHB   = 5
) (
    input  shr_src_e               src,
    input  logic [CIN_W-1:0]       imm,
    input  logic [CIN_W-1:0]       reg_cnt,
    output logic [CIN_W-1:0]       n_rot,
    output logic [CIN_W-1:0]       n_rcx,
    output logic [CIN_W-1:0]       n_sh
);
    localparam logic [CIN_W-1:0] ROT_MASK = CIN_W'(W - 1);
    localparam logic [CIN_W-1:0] SH_MASK  = CIN_W'((1 << SHB) - 1);
    localparam logic [CIN_W-1:0] RCX_MOD  = CIN_W'(W + 1);

    logic [CIN_W-1:0] raw;

    always_comb begin
        case (src)
            SRC_ONE: raw = CIN_W'(1);
            SRC_IMM: raw = imm;
            default: raw = reg_cnt;
        endcase
        n_rot = raw & ROT_MASK;
        n_sh  = raw & SH_MASK;
        n_rcx = n_sh % RCX_MOD;
    end

endmodule

// File: rtl/shr_rotate.sv
module shr_rotate
    import shr_pkg::*;
#(
    parameter int W     = 8,
    parameter int CIN_W = 8
) (
    input  shr_op_e          op,
    input  logic [W-1:0]     val,
    input  logic             cin,
    input  logic [CIN_W-1:0] n_rot,
    input  logic [CIN_W-1:0] n_rcx,
    output logic [W-1:0]     res,
    output logic             active,
    output flag_t            cf_f,
    output flag_t            ovf_f
);
    localparam logic [CIN_W-1:0] SPAN   = CIN_W'(W);
    localparam logic [CIN_W-1:0] SPAN_C = CIN_W'(W + 1);
    localparam logic [CIN_W-1:0] ONE    = CIN_W'(1);

    logic [W:0]       nine;
    logic [W:0]       car_res;
    logic [CIN_W-1:0] n;
    logic             cfv;

    always_comb begin
        nine    = {cin, val};
        car_res = '0;
        res     = val;
        cfv     = 1'b0;
        n       = '0;
        case (op)
            OP_ROL: begin
                n   = n_rot;
                res = (val << n_rot) | (val >> (SPAN - n_rot));
                cfv = res[0];
            end
            OP_ROR: begin
                n   = n_rot;
                res = (val >> n_rot) | (val << (SPAN - n_rot));
                cfv = res[W-1];
            end
            OP_RCL: begin
                n       = n_rcx;
                car_res = (nine << n_rcx) | (nine >> (SPAN_C - n_rcx));
                res     = car_res[W-1:0];
                cfv     = car_res[W];
            end
            OP_RCR: begin
                n       = n_rcx;
                car_res = (nine >> n_rcx) | (nine << (SPAN_C - n_rcx));
                res     = car_res[W-1:0];
                cfv     = car_res[W];
            end
            default: ;
        endcase
        active = (n != '0);
        cf_f   = mk_flag(active, cfv);
        ovf_f  = mk_flag(n == ONE, val[W-1] ^ res[W-1]);
    end

endmodule

// File: rtl/shr_shift.sv
module shr_shift
    import shr_pkg::*;
#(
    parameter int W     = 8,
    parameter int CIN_W = 8
) (
    input  shr_op_e          op,
    input  logic [W-1:0]     val,
    input  logic [CIN_W-1:0] n_sh,
    output logic [W-1:0]     res,
    output logic             active,
    output flag_t            cf_f,
    output flag_t            ovf_f,
    output flag_t            sgn_f,
    output flag_t            zro_f,
    output flag_t            par_f
);
    localparam logic [CIN_W-1:0] ONE = CIN_W'(1);

    logic [W:0]        lt;  // {last out, result}
    logic [W:0]        rt;  // {result, last out}
    logic signed [W:0] at;
    logic              cfv;
    logic              ofv;

    always_comb begin
        lt  = {1'b0, val} << n_sh;
        rt  = {val, 1'b0} >> n_sh;
        at  = signed'({val, 1'b0}) >>> n_sh;
        res = val;
        cfv = 1'b0;
        ofv = 1'b0;
        case (op)
            OP_SHL: begin
                res = lt[W-1:0];
                cfv = lt[W];
                ofv = lt[W-1] ^ lt[W];
            end
            OP_SHR: begin
                res = rt[W:1];
                cfv = rt[0];
                ofv = val[W-1];
            end
            OP_SAR: begin
                res = at[W:1];
                cfv = at[0];
                ofv = 1'b0;
            end
            default: ;
        endcase
        active = is_shift(op) && (n_sh != '0);
        cf_f   = mk_flag(active, cfv);
        ovf_f  = mk_flag(active && (n_sh == ONE), ofv);
        sgn_f  = mk_flag(active, res[W-1]);
        zro_f  = mk_flag(active, res == '0);
        par_f  = mk_flag(active, ~^res);
    end

endmodule

// File: rtl/shr_byte_unit.sv
module shr_byte_unit
    import shr_pkg::*;
#(
    parameter int W     = 8,
    parameter int CIN_W = 8,
    parameter int SHB   = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       op_sel,
    input  logic [1:0]       cnt_src,
    input  logic [CIN_W-1:0] cnt_imm,
    input  logic [CIN_W-1:0] cnt_reg,
    input  logic [W-1:0]     operand,
    input  logic             carry_in,
    output logic [W-1:0]     result,
    output logic             wr_en,
    output logic             cf_we,
    output logic             cf_out,
    output logic             of_we,
    output logic             of_out,
    output logic             sf_we,
    output logic             sf_out,
    output logic             zf_we,
    output logic             zf_out,
    output logic             pf_we,
    output logic             pf_out
);
    shr_op_e          op;
    logic [CIN_W-1:0] n_rot, n_rcx, n_sh;
    logic [W-1:0]     rot_res, sh_res;
    logic             rot_act, sh_act;
    flag_t            rot_cf, rot_ovf;
    flag_t            sh_cf, sh_ovf, sh_sgn, sh_zro, sh_par;

    logic [W-1:0]     nxt_res;
    logic             nxt_wr;
    flag_set_t        nxt_flags;

    logic [W-1:0]     q_res;
    logic             q_wr;
    flag_set_t        q_flags;

    assign op = shr_op_e'(op_sel);

    shr_count_sel #(.W(W), .CIN_W(CIN_W), .SHB(SHB)) u_cnt (
        .src     (shr_src_e'(cnt_src)),
        .imm     (cnt_imm),
        .reg_cnt (cnt_reg),
        .n_rot   (n_rot),
        .n_rcx   (n_rcx),
        .n_sh    (n_sh)
    );

    shr_rotate #(.W(W), .CIN_W(CIN_W)) u_rot (
        .op     (op),
        .val    (operand),
        .cin    (carry_in),
        .n_rot  (n_rot),
        .n_rcx  (n_rcx),
        .res    (rot_res),
        .active (rot_act),
        .cf_f   (rot_cf),
        .ovf_f  (rot_ovf)
    );

    shr_shift #(.W(W), .CIN_W(CIN_W)) u_sh (
        .op     (op),
        .val    (operand),
        .n_sh   (n_sh),
        .res    (sh_res),
        .active (sh_act),
        .cf_f   (sh_cf),
        .ovf_f  (sh_ovf),
        .sgn_f  (sh_sgn),
        .zro_f  (sh_zro),
        .par_f  (sh_par)
    );

    always_comb begin
        nxt_res   = operand;
        nxt_wr    = 1'b0;
        nxt_flags = '{cf: FLAG_KEEP, ovf: FLAG_KEEP, sgn: FLAG_KEEP,
                      zro: FLAG_KEEP, par: FLAG_KEEP};
        if (is_rotate(op) && rot_act) begin
            nxt_res       = rot_res;
            nxt_wr        = 1'b1;
            nxt_flags.cf  = rot_cf;
            nxt_flags.ovf = rot_ovf;
        end else if (sh_act) begin
            nxt_res   = sh_res;
            nxt_wr    = 1'b1;
            nxt_flags = '{cf: sh_cf, ovf: sh_ovf, sgn: sh_sgn,
                          zro: sh_zro, par: sh_par};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_res   <= '0;
            q_wr    <= 1'b0;
            q_flags <= '0;
        end else begin
            q_res   <= nxt_res;
            q_wr    <= nxt_wr;
            q_flags <= nxt_flags;
        end
    end

    assign result = q_res;
    assign wr_en  = q_wr;
    assign cf_we  = q_flags.cf.we;
    assign cf_out = q_flags.cf.val;
    assign of_we  = q_flags.ovf.we;
    assign of_out = q_flags.ovf.val;
    assign sf_we  = q_flags.sgn.we;
    assign sf_out = q_flags.sgn.val;
    assign zf_we  = q_flags.zro.we;
    assign zf_out = q_flags.zro.val;
    assign pf_we  = q_flags.par.we;
    assign pf_out = q_flags.par.val;

    a_r1_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!wr_en && result == '0 && !cf_we && !of_we));

    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !wr_en |-> !(cf_we || of_we || sf_we || zf_we || pf_we));

    a_r9_operand_kept: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !$past(rst)) |-> (result == $past(operand)));

    a_r10_disabled_zero: assert property (@(posedge clk) disable iff (rst)
        !(( !cf_we && cf_out) || (!of_we && of_out) || (!sf_we && sf_out) ||
          (!zf_we && zf_out) || (!pf_we && pf_out)));

    a_r6_rotate_no_szp: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !$past(rst) && !$past(op_sel[2])) |-> (!sf_we && !zf_we && !pf_we));

    a_r3_rol_carry: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !$past(rst) && $past(op_sel) == 3'd0) |-> (cf_out == result[0]));

    a_r8_parity: assert property (@(posedge clk) disable iff (rst)
        pf_we |-> (pf_out == ~^result));

    a_r8_sar_of_clear: assert property (@(posedge clk) disable iff (rst)
        (of_we && !$past(rst) && $past(op_sel) == 3'd7) |-> !of_out);

endmodule

// File: tb/shr_byte_unit_bench.sv
module shr_byte_unit_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] op_sel;
    logic [1:0] cnt_src;
    logic [7:0] cnt_imm, cnt_reg, operand;
    logic       carry_in;
    logic [7:0] result;
    logic       wr_en, cf_we, cf_out, of_we, of_out;
    logic       sf_we, sf_out, zf_we, zf_out, pf_we, pf_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 4 ns period

    shr_byte_unit u_shr_byte_unit (
        .clk(clk), .rst(rst), .op_sel(op_sel), .cnt_src(cnt_src),
        .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .operand(operand),
        .carry_in(carry_in), .result(result), .wr_en(wr_en),
        .cf_we(cf_we), .cf_out(cf_out), .of_we(of_we), .of_out(of_out),
        .sf_we(sf_we), .sf_out(sf_out), .zf_we(zf_we), .zf_out(zf_out),
        .pf_we(pf_we), .pf_out(pf_out)
    );

    // layout: {wr, res[7:0], cfwe, cf, ofwe, of, sfwe, sf, zfwe, zf, pfwe, pf}
    function automatic logic [18:0] model(input logic [2:0] op, input logic [7:0] v,
                                          input logic [7:0] raw, input logic ci);
        logic [7:0] r;
        logic       c;
        int         n;
        logic       ofv;
        logic       ofwe;
        logic [5:0] szp;
        r = v; c = ci; ofv = 1'b0; szp = 6'b0;
        case (op)
            3'd0, 3'd1:       n = raw % 8;
            3'd2, 3'd3:       n = (raw % 32) % 9;
            3'd4, 3'd5, 3'd7: n = raw % 32;
            default:          n = 0;
        endcase
        for (int i = 0; i < n; i++) begin
            case (op)
                3'd0: r = {r[6:0], r[7]};
                3'd1: r = {r[0], r[7:1]};
                3'd2: {c, r} = {r, c};
                3'd3: {r, c} = {c, r};
                3'd4: begin c = r[7]; r = {r[6:0], 1'b0}; end
                3'd5: begin c = r[0]; r = {1'b0, r[7:1]}; end
                default: begin c = r[0]; r = {r[7], r[7:1]}; end
            endcase
        end
        if (n == 0) return {1'b0, v, 10'b0};
        if (op == 3'd0) c = r[0];
        if (op == 3'd1) c = r[7];
        case (op)
            3'd4:    ofv = r[7] ^ c;
            3'd5:    ofv = v[7];
            3'd7:    ofv = 1'b0;
            default: ofv = v[7] ^ r[7];
        endcase
        ofwe = (n == 1);
        if (op >= 3'd4) szp = {1'b1, r[7], 1'b1, (r == 8'h00), 1'b1, ~^r};
        return {1'b1, r, 1'b1, c, ofwe, ofwe & ofv, szp};
    endfunction

    function automatic logic [18:0] observed();
        return {wr_en, result, cf_we, cf_out, of_we, of_out,
                sf_we, sf_out, zf_we, zf_out, pf_we, pf_out};
    endfunction

    task automatic chk(input string tag, input logic [18:0] got, input logic [18:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%0d opnd=%h src=%0d imm=%h reg=%h cin=%b got=%h exp=%h",
                     tag, op_sel, operand, cnt_src, cnt_imm, cnt_reg, carry_in, got, exp);
        end
    endtask

    function automatic logic [7:0] raw_of(input logic [1:0] s, input logic [7:0] im,
                                          input logic [7:0] rg);
        if (s == 2'd0) return 8'd1;
        if (s == 2'd1) return im;
        return rg;
    endfunction

    task automatic apply(input logic [2:0] op, input logic [7:0] v, input logic [1:0] s,
                         input logic [7:0] im, input logic [7:0] rg, input logic ci);
        op_sel = op; operand = v; cnt_src = s; cnt_imm = im; cnt_reg = rg; carry_in = ci;
    endtask

    // split comparison so each requirement gets its own check
    task automatic check_all(input logic [18:0] exp);
        logic [18:0] got;
        string t_main, t_of, t_szp;
        got = observed();
        if (!exp[18]) begin
            t_main = "R9"; t_of = "R10"; t_szp = "R10";
        end else if (op_sel <= 3'd1) begin
            t_main = "R3"; t_of = "R5"; t_szp = "R6";
        end else if (op_sel <= 3'd3) begin
            t_main = "R4"; t_of = "R5"; t_szp = "R6";
        end else begin
            t_main = "R7"; t_of = "R8"; t_szp = "R8";
        end
        chk(t_main, {10'b0, got[18:9]}, {10'b0, exp[18:9]});
        chk(t_of,   {17'b0, got[8:7]} , {17'b0, exp[8:7]});
        chk(t_of,   {17'b0, got[7:6]} , {17'b0, exp[7:6]});
        chk(t_szp,  {13'b0, got[5:0]} , {13'b0, exp[5:0]});
    endtask

    initial begin
        rst = 1'b1;
        apply(3'd4, 8'h5A, 2'd1, 8'd3, 8'd2, 1'b1);
        repeat (3) @(negedge clk);
        chk("R1", observed(), 19'b0);  // R1 reset clears every output
        rst = 1'b0;

        // R2: count source choice with SHL of 0x01
        apply(3'd4, 8'h01, 2'd0, 8'd3, 8'd5, 1'b0);
        @(negedge clk);
        chk("R2", {11'b0, result}, {11'b0, 8'h02});
        apply(3'd4, 8'h01, 2'd1, 8'd3, 8'd5, 1'b0);
        @(negedge clk);
        chk("R2", {11'b0, result}, {11'b0, 8'h08});
        apply(3'd4, 8'h01, 2'd2, 8'd3, 8'd5, 1'b0);
        @(negedge clk);
        chk("R2", {11'b0, result}, {11'b0, 8'h20});
        apply(3'd4, 8'h01, 2'd3, 8'd3, 8'd6, 1'b0);
        @(negedge clk);
        chk("R2", {11'b0, result}, {11'b0, 8'h40});

        // R1: registered output holds until the next edge
        apply(3'd0, 8'h81, 2'd0, 8'd0, 8'd0, 1'b0);
        #1;
        chk("R1", {11'b0, result}, {11'b0, 8'h40});
        @(negedge clk);
        chk("R1", observed(), model(3'd0, 8'h81, 8'd1, 1'b0));

        // full sweep: op x operand x count x carry
        for (int op = 0; op < 8; op++) begin
            for (int v = 0; v < 256; v++) begin
                for (int c = 0; c < 32; c++) begin
                    for (int ci = 0; ci < 2; ci++) begin
                        logic [7:0] raw, im, rg;
                        logic [1:0] s;
                        s   = 2'(v) ^ 2'(c);
                        raw = {3'(v >> 5) ^ 3'(ci), 5'(c)};
                        im  = (s == 2'd1) ? raw : ~raw;
                        rg  = (s[1]) ? raw : ~raw;
                        apply(3'(op), 8'(v), s, im, rg, 1'(ci));
                        @(negedge clk);
                        check_all(model(3'(op), 8'(v), raw_of(s, im, rg), 1'(ci)));
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule